// File: doc/BRIEF.md
# Configurable SPI Slave Port

This block is a byte-oriented SPI slave that runs entirely in the system clock domain. The serial clock, data-in and active-low select pins pass through multi-stage synchronisers. Clock edges are then found by comparing successive synchronised samples. Configuration inputs set the clock idle level and the sampling edge independently of each other. They also set the bit order for each direction separately.

The host side has two byte queues. Bytes written into the transmit queue are shifted out to the master. Bytes shifted in from the master land in the receive queue, where the host reads them.

A configurable filler value sent by the master is recognised and never stored. When the transmit queue has run dry, the slave sends a configurable terminator value. An attention output tells the master that the slave holds unread data, and it has four drive styles. When the handshake is enabled, a full indication reports that reception is blocked.

Top module: `spi_slave_port`

## Requirements
- R1: Each of the four combinations of clock idle level (`cfg_idle_high`) and sampling edge (`cfg_sample_fall`) transfers bytes correctly in both directions. Data in is captured on the selected edge and data out changes on the other edge. The defaults of 0 and 0 mean idle low with sampling on the rising edge.
- R2: Receive and transmit bit order are chosen independently of each other. A value of 0 on `cfg_rx_lsb` or `cfg_tx_lsb` sends the most significant bit first, and a value of 1 sends the least significant bit first.
- R3: A falling edge on `spi_ss_n` restarts the bit count. Bits left over from an incomplete byte are discarded, and the next eight sampling edges form a complete new byte.
- R4: A received byte equal to `cfg_dummy` is never written into the receive queue.
- R5: A byte slot that starts while the transmit queue is empty shifts out `cfg_end`.
- R6: Consecutive bytes within one select window need no gap between them. The next transmit byte is placed in the shifter in the same bit period in which the current byte ends.
- R7: The attention pins {`attn_oe`,`attn_o`} follow `cfg_attn_mode`. There are four modes: 0 is unused, 1 is active low, 2 is active high and 3 is buffered. In mode 0 the pins read 00 at all times. With no transmit data waiting, mode 1 gives 11, mode 2 gives 10 and mode 3 gives 00. With transmit data waiting, mode 1 gives 10, mode 2 gives 11 and mode 3 gives 10.
- R8: When `cfg_handshake` is 1, `rx_full_o` is high while the receive queue is full or `cfg_rx_en` is 0. When `cfg_handshake` is 0, `rx_full_o` stays low. A byte received while `cfg_rx_en` is 0 is dropped and does not raise the overflow flag.
- R9: A byte that arrives while the receive queue is full is dropped and sets `rx_ovf`. The flag stays set until a pulse on `rx_ovf_clr` clears it.
- R10: `miso_oe` is 0 while `spi_ss_n` is high and 1 while it is low.
- R11: Both queues keep first-in first-out order. A write while `tx_full` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ss_n | input | 1 | Active-low select from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso_o` |
| attn_o | output | 1 | Attention pin value |
| attn_oe | output | 1 | Attention pin output enable |
| rx_full_o | output | 1 | Receive blocked indication (handshake) |
| cfg_idle_high | input | 1 | Clock idles high when 1 |
| cfg_sample_fall | input | 1 | Sample on the falling clock edge when 1 |
| cfg_rx_lsb | input | 1 | Receive least significant bit first when 1 |
| cfg_tx_lsb | input | 1 | Transmit least significant bit first when 1 |
| cfg_dummy | input | DATA_W | Filler value discarded on receive |
| cfg_end | input | DATA_W | Value sent while the transmit queue is empty |
| cfg_attn_mode | input | 2 | Attention drive style |
| cfg_handshake | input | 1 | Enables `rx_full_o` |
| cfg_rx_en | input | 1 | Receive enable |
| tx_wr_en | input | 1 | Transmit queue write strobe |
| tx_wr_data | input | DATA_W | Transmit queue write data |
| tx_full | output | 1 | Transmit queue full |
| rx_rd_en | input | 1 | Receive queue read strobe |
| rx_rd_data | output | DATA_W | Head of the receive queue |
| rx_avail | output | 1 | Receive queue not empty |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| rx_ovf_clr | input | 1 | Clears `rx_ovf` |

## Verification
All sixteen combinations of idle level, sampling edge and per-direction bit order are run with three-byte frames. Swapped orders or a wrong edge therefore show up as corrupted bytes on one side only. Every byte value from 0 to 255 is sent and echoed in the default mode. This sweep separates a lost or altered bit from the single filler value, which must vanish. Short frames, a truncated frame, deliberate overfill of both queues and all four attention styles cover the framing, terminator, drop and sticky-flag behaviour.

// File: rtl/spi_slave_pkg.sv
`timescale 1ns/1ps
package spi_slave_pkg;

   typedef enum logic [1:0] {
      ATTN_OFF  = 2'd0,
      ATTN_LOW  = 2'd1,
      ATTN_HIGH = 2'd2,
      ATTN_BUF  = 2'd3
   } attn_mode_e;

endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_byte_fifo.sv
`timescale 1ns/1ps
module spi_byte_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] pop_data,
   output logic         empty,
   output logic         full
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
   localparam logic [NW-1:0] CNT_FULL = NW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_byte_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("spi_byte_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [NW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty    = (cnt == '0);
   assign full     = (cnt == CNT_FULL);
   assign do_push  = push & ~full;
   assign do_pop   = pop & ~empty;
   assign pop_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + NW'(1);
            2'b01:   cnt <= cnt - NW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> ($stable(cnt) && full)); // R11

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty); // R11

endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sck_s,
   input  logic         mosi_s,
   input  logic         ss_n_s,
   input  logic         cfg_idle_high,
   input  logic         cfg_sample_fall,
   input  logic         cfg_rx_lsb,
   input  logic         cfg_tx_lsb,
   input  logic [W-1:0] cfg_dummy,
   input  logic [W-1:0] cfg_end,
   input  logic         txq_empty,
   input  logic [W-1:0] txq_data,
   output logic         txq_pop,
   output logic         rx_valid,
   output logic [W-1:0] rx_byte,
   output logic         tx_held,
   output logic         miso_o,
   output logic         miso_oe
);

   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   if (W < 2) begin : g_bad_width
      $error("spi_shift_engine: W must be at least 2");
   end

   function automatic logic [W-1:0] flip(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   logic          sck_n, sck_nd, ss_nd;
   logic          lead, trail, active, lead_samples;
   logic          smp, lch, ss_fall, byte_done, load_req;
   logic [CW-1:0] bit_cnt;
   logic [W-1:0]  rx_sh, tx_sh, rx_word, rx_out, tx_next, tx_load, end_ordered;
   logic          fresh, from_q;

   always_comb begin
      sck_n        = sck_s ^ cfg_idle_high;
      lead         = sck_n & ~sck_nd;
      trail        = ~sck_n & sck_nd;
      active       = ~ss_n_s;
      lead_samples = (cfg_idle_high == cfg_sample_fall);
      smp          = active & (lead_samples ? lead : trail);
      lch          = active & (lead_samples ? trail : lead);
      ss_fall      = ss_nd & ~ss_n_s;
      byte_done    = smp & (bit_cnt == LAST);
      rx_word      = {rx_sh[W-2:0], mosi_s};
      rx_out       = cfg_rx_lsb ? flip(rx_word) : rx_word;
      tx_next      = txq_empty ? cfg_end : txq_data;
      tx_load      = cfg_tx_lsb ? flip(tx_next) : tx_next;
      end_ordered  = cfg_tx_lsb ? flip(cfg_end) : cfg_end;
      load_req     = byte_done | (ss_fall & ~(fresh & from_q));
   end

   assign txq_pop = load_req & ~txq_empty;
   assign tx_held = fresh & from_q;
   assign miso_o  = tx_sh[W-1];
   assign miso_oe = active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_nd   <= 1'b0;
         ss_nd    <= 1'b1;
         bit_cnt  <= '0;
         rx_sh    <= '0;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
         tx_sh    <= '0;
         fresh    <= 1'b0;
         from_q   <= 1'b0;
      end else begin
         sck_nd   <= sck_n;
         ss_nd    <= ss_n_s;
         rx_valid <= byte_done & (rx_out != cfg_dummy);
         if (byte_done) rx_byte <= rx_out;
         if (smp) rx_sh <= rx_word;

         if (ss_fall)        bit_cnt <= '0;
         else if (byte_done) bit_cnt <= '0;
         else if (smp)       bit_cnt <= bit_cnt + CW'(1);

         if (load_req) begin
            tx_sh  <= tx_load;
            fresh  <= 1'b1;
            from_q <= ~txq_empty;
         end else if (lch && (bit_cnt != '0)) begin
            tx_sh  <= {tx_sh[W-2:0], 1'b0};
            fresh  <= 1'b0;
         end
      end
   end

   AST_SSFALL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      ss_fall |=> (bit_cnt == '0)); // R3

   AST_DUMMY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (rx_byte != cfg_dummy)); // R4

   AST_END_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && txq_empty) |=> (tx_sh == $past(end_ordered))); // R5

   AST_NEXT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> fresh); // R6

endmodule

// File: rtl/spi_slave_port.sv
`timescale 1ns/1ps
module spi_slave_port
   import spi_slave_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int RXQ_DEPTH   = 4,
   parameter int TXQ_DEPTH   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   input  logic              spi_ss_n,
   output logic              miso_o,
   output logic              miso_oe,
   output logic              attn_o,
   output logic              attn_oe,
   output logic              rx_full_o,
   input  logic              cfg_idle_high,
   input  logic              cfg_sample_fall,
   input  logic              cfg_rx_lsb,
   input  logic              cfg_tx_lsb,
   input  logic [DATA_W-1:0] cfg_dummy,
   input  logic [DATA_W-1:0] cfg_end,
   input  logic [1:0]        cfg_attn_mode,
   input  logic              cfg_handshake,
   input  logic              cfg_rx_en,
   input  logic              tx_wr_en,
   input  logic [DATA_W-1:0] tx_wr_data,
   output logic              tx_full,
   input  logic              rx_rd_en,
   output logic [DATA_W-1:0] rx_rd_data,
   output logic              rx_avail,
   output logic              rx_ovf,
   input  logic              rx_ovf_clr
);

   localparam int            PIN_W   = 3;
   localparam logic [PIN_W-1:0] PIN_RST = 3'b100;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("spi_slave_port: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_slave_port: SYNC_STAGES must be at least 2");
   end

   logic [PIN_W-1:0]  pins_s;
   logic              sck_s, mosi_s, ss_n_s;
   logic              txq_empty, txq_pop, rxq_full, rxq_empty;
   logic [DATA_W-1:0] txq_data, rx_byte;
   logic              rx_valid, rx_push, rx_lost, tx_held, tx_waiting;
   attn_mode_e        mode;

   spi_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_ss_n, spi_sck, spi_mosi}),
      .q     (pins_s)
   );
   assign {ss_n_s, sck_s, mosi_s} = pins_s;

   spi_byte_fifo #(.W(DATA_W), .DEPTH(TXQ_DEPTH)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (tx_wr_en),
      .push_data (tx_wr_data),
      .pop       (txq_pop),
      .pop_data  (txq_data),
      .empty     (txq_empty),
      .full      (tx_full)
   );

   spi_shift_engine #(.W(DATA_W)) u_eng (
      .clk             (clk),
      .rst_n           (rst_n),
      .sck_s           (sck_s),
      .mosi_s          (mosi_s),
      .ss_n_s          (ss_n_s),
      .cfg_idle_high   (cfg_idle_high),
      .cfg_sample_fall (cfg_sample_fall),
      .cfg_rx_lsb      (cfg_rx_lsb),
      .cfg_tx_lsb      (cfg_tx_lsb),
      .cfg_dummy       (cfg_dummy),
      .cfg_end         (cfg_end),
      .txq_empty       (txq_empty),
      .txq_data        (txq_data),
      .txq_pop         (txq_pop),
      .rx_valid        (rx_valid),
      .rx_byte         (rx_byte),
      .tx_held         (tx_held),
      .miso_o          (miso_o),
      .miso_oe         (miso_oe)
   );

   assign rx_push = rx_valid & cfg_rx_en & ~rxq_full;
   assign rx_lost = rx_valid & cfg_rx_en & rxq_full;

   spi_byte_fifo #(.W(DATA_W), .DEPTH(RXQ_DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_push),
      .push_data (rx_byte),
      .pop       (rx_rd_en),
      .pop_data  (rx_rd_data),
      .empty     (rxq_empty),
      .full      (rxq_full)
   );

   assign rx_avail  = ~rxq_empty;
   assign rx_full_o = cfg_handshake & (rxq_full | ~cfg_rx_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rx_ovf <= 1'b0;
      else if (rx_lost)    rx_ovf <= 1'b1;
      else if (rx_ovf_clr) rx_ovf <= 1'b0;
   end

   assign tx_waiting = ~txq_empty | tx_held;
   assign mode       = attn_mode_e'(cfg_attn_mode);

   always_comb begin
      case (mode)
         ATTN_LOW:  begin attn_oe = 1'b1;       attn_o = ~tx_waiting; end
         ATTN_HIGH: begin attn_oe = 1'b1;       attn_o = tx_waiting;  end
         ATTN_BUF:  begin attn_oe = tx_waiting; attn_o = 1'b0;        end
         default:   begin attn_oe = 1'b0;       attn_o = 1'b0;        end
      endcase
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf && !rx_ovf_clr) |=> rx_ovf); // R9

   AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_rx_en && rxq_full) |=> rx_ovf); // R9

   AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cfg_rx_en) |=> $stable(rxq_empty) || !rxq_empty); // R8

endmodule

// File: tb/spi_slave_port_test.sv
`timescale 1ns/1ps
module spi_slave_port_test;

   localparam int HP        = 8;
   localparam logic [7:0] DUMMY = 8'hA5;
   localparam logic [7:0] ENDV  = 8'hE7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_ss_n = 1'b1;
   logic       miso_o, miso_oe, attn_o, attn_oe, rx_full_o;
   logic       cfg_idle_high = 1'b0, cfg_sample_fall = 1'b0;
   logic       cfg_rx_lsb = 1'b0, cfg_tx_lsb = 1'b0;
   logic [1:0] cfg_attn_mode = 2'd1;
   logic       cfg_handshake = 1'b0, cfg_rx_en = 1'b1;
   logic       tx_wr_en = 1'b0, rx_rd_en = 1'b0, rx_ovf_clr = 1'b0;
   logic [7:0] tx_wr_data = 8'h00;
   logic       tx_full, rx_avail, rx_ovf;
   logic [7:0] rx_rd_data;

   int total = 0;
   int bad   = 0;
   logic [7:0] m_out [8];
   logic [7:0] m_in  [8];

   always #10 clk = ~clk;

   spi_slave_port uut (
      .clk(clk), .rst_n(rst_n),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n),
      .miso_o(miso_o), .miso_oe(miso_oe), .attn_o(attn_o), .attn_oe(attn_oe),
      .rx_full_o(rx_full_o),
      .cfg_idle_high(cfg_idle_high), .cfg_sample_fall(cfg_sample_fall),
      .cfg_rx_lsb(cfg_rx_lsb), .cfg_tx_lsb(cfg_tx_lsb),
      .cfg_dummy(DUMMY), .cfg_end(ENDV), .cfg_attn_mode(cfg_attn_mode),
      .cfg_handshake(cfg_handshake), .cfg_rx_en(cfg_rx_en),
      .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
      .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_avail(rx_avail),
      .rx_ovf(rx_ovf), .rx_ovf_clr(rx_ovf_clr)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tx_push(input logic [7:0] v);
      @(negedge clk);
      tx_wr_en   = 1'b1;
      tx_wr_data = v;
      @(negedge clk);
      tx_wr_en   = 1'b0;
   endtask

   task automatic rx_pop(output logic [7:0] v, output logic a);
      @(negedge clk);
      v = rx_rd_data;
      a = rx_avail;
      rx_rd_en = a;
      @(negedge clk);
      rx_rd_en = 1'b0;
   endtask

   task automatic frame(input int n);
      logic lead_smp;
      lead_smp = (cfg_idle_high == cfg_sample_fall);
      spi_sck  = cfg_idle_high;
      wait_cyc(4);
      spi_ss_n = 1'b0;
      wait_cyc(HP);
      for (int k = 0; k < n; k++) begin
         for (int i = 0; i < 8; i++) begin
            if (lead_smp) begin
               spi_mosi = cfg_rx_lsb ? m_out[k][i] : m_out[k][7-i];
               wait_cyc(HP);
               spi_sck = ~cfg_idle_high;
               m_in[k][cfg_tx_lsb ? i : 7-i] = miso_o;
               wait_cyc(HP);
               spi_sck = cfg_idle_high;
            end else begin
               spi_sck  = ~cfg_idle_high;
               spi_mosi = cfg_rx_lsb ? m_out[k][i] : m_out[k][7-i];
               wait_cyc(HP);
               spi_sck = cfg_idle_high;
               m_in[k][cfg_tx_lsb ? i : 7-i] = miso_o;
               wait_cyc(HP);
            end
         end
      end
      wait_cyc(HP);
      spi_ss_n = 1'b1;
      wait_cyc(8);
   endtask

   task automatic partial(input int nb);
      spi_sck = cfg_idle_high;
      wait_cyc(4);
      spi_ss_n = 1'b0;
      wait_cyc(HP);
      chk("R10 miso_oe while selected", int'(miso_oe), 1);
      for (int i = 0; i < nb; i++) begin
         spi_mosi = 1'b1;
         wait_cyc(HP);
         spi_sck = ~cfg_idle_high;
         wait_cyc(HP);
         spi_sck = cfg_idle_high;
      end
      wait_cyc(HP);
      spi_ss_n = 1'b1;
      wait_cyc(8);
      chk("R10 miso_oe after deselect", int'(miso_oe), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v, a8, b8;
      logic       av;
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(4);

      // reset state
      chk("R10 reset miso_oe", int'(miso_oe), 0);
      chk("R11 reset rx_avail", int'(rx_avail), 0);
      chk("R11 reset tx_full", int'(tx_full), 0);
      chk("R9 reset rx_ovf", int'(rx_ovf), 0);
      chk("R7 reset attention mode1", int'({attn_oe, attn_o}), 3);

      // R1 R2 R5 R6: all idle/edge/order combinations
      for (int c = 0; c < 16; c++) begin
         cfg_idle_high   = c[0];
         cfg_sample_fall = c[1];
         cfg_rx_lsb      = c[2];
         cfg_tx_lsb      = c[3];
         wait_cyc(4);
         a8 = 8'h3C ^ 8'(c * 7);
         b8 = ~a8;
         tx_push(a8);
         tx_push(b8);
         m_out[0] = 8'h81 + 8'(c * 5);
         m_out[1] = 8'h42 ^ 8'(c << 2);
         m_out[2] = 8'h17 + 8'(c);
         frame(3);
         chk($sformatf("R1 R2 cfg%0d first byte out", c), int'(m_in[0]), int'(a8));
         chk($sformatf("R6 cfg%0d back-to-back byte out", c), int'(m_in[1]), int'(b8));
         chk($sformatf("R5 cfg%0d end byte", c), int'(m_in[2]), int'(ENDV));
         for (int k = 0; k < 3; k++) begin
            rx_pop(v, av);
            chk($sformatf("R1 R2 cfg%0d rx byte %0d", c, k), int'(v), int'(m_out[k]));
         end
         rx_pop(v, av);
         chk($sformatf("R11 cfg%0d rx empty", c), int'(av), 0);
      end

      cfg_idle_high = 1'b0; cfg_sample_fall = 1'b0;
      cfg_rx_lsb = 1'b0; cfg_tx_lsb = 1'b0;
      wait_cyc(4);

      // R1 R4: every byte value in the default mode
      for (int x = 0; x < 256; x++) begin
         tx_push(8'(x));
         m_out[0] = 8'(x);
         frame(1);
         chk("R1 echo value out", int'(m_in[0]), x);
         rx_pop(v, av);
         if (8'(x) == DUMMY) chk("R4 dummy not stored", int'(av), 0);
         else                chk("R1 value in", int'({av, v}), 256 + x);
      end

      // R3: truncated frame then a full one
      partial(3);
      tx_push(8'h6B);
      m_out[0] = 8'h2D;
      frame(1);
      chk("R3 miso after restart", int'(m_in[0]), 8'h6B);
      rx_pop(v, av);
      chk("R3 rx after restart", int'({av, v}), 256 + 8'h2D);
      rx_pop(v, av);
      chk("R3 no stray byte", int'(av), 0);

      // R7: attention modes
      for (int md = 0; md < 4; md++) begin
         cfg_attn_mode = 2'(md);
         wait_cyc(2);
         chk($sformatf("R7 mode%0d idle", md), int'({attn_oe, attn_o}),
             (md == 1) ? 3 : (md == 2) ? 2 : 0);
         tx_push(8'h99);
         wait_cyc(4);
         chk($sformatf("R7 mode%0d waiting", md), int'({attn_oe, attn_o}),
             (md == 0) ? 0 : (md == 2) ? 3 : 2);
         m_out[0] = 8'h10;
         frame(1);
         chk($sformatf("R7 mode%0d sent", md), int'(m_in[0]), 8'h99);
         rx_pop(v, av);
         chk($sformatf("R7 mode%0d drained", md), int'({attn_oe, attn_o}),
             (md == 1) ? 3 : (md == 2) ? 2 : 0);
      end
      cfg_attn_mode = 2'd1;

      // R8 R9: full flag and sticky overflow
      cfg_handshake = 1'b1;
      wait_cyc(2);
      chk("R8 not full at start", int'(rx_full_o), 0);
      for (int k = 0; k < 4; k++) m_out[k] = 8'h20 + 8'(k);
      frame(4);
      chk("R8 full after four", int'(rx_full_o), 1);
      chk("R9 no overflow yet", int'(rx_ovf), 0);
      m_out[0] = 8'h24;
      frame(1);
      chk("R9 overflow set", int'(rx_ovf), 1);
      for (int k = 0; k < 4; k++) begin
         rx_pop(v, av);
         chk("R9 kept oldest bytes", int'(v), 8'h20 + k);
      end
      rx_pop(v, av);
      chk("R9 new byte dropped", int'(av), 0);
      chk("R8 full cleared", int'(rx_full_o), 0);
      chk("R9 flag sticky", int'(rx_ovf), 1);
      @(negedge clk); rx_ovf_clr = 1'b1;
      @(negedge clk); rx_ovf_clr = 1'b0;
      chk("R9 flag cleared", int'(rx_ovf), 0);
      cfg_rx_en = 1'b0;
      wait_cyc(2);
      chk("R8 full while disabled", int'(rx_full_o), 1);
      m_out[0] = 8'h33;
      frame(1);
      rx_pop(v, av);
      chk("R8 disabled drops byte", int'(av), 0);
      chk("R8 disabled no overflow", int'(rx_ovf), 0);
      cfg_handshake = 1'b0;
      wait_cyc(2);
      chk("R8 handshake off", int'(rx_full_o), 0);
      cfg_rx_en = 1'b1;

      // R11: transmit queue write while full is ignored
      for (int k = 0; k < 5; k++) begin
         tx_push(8'h50 + 8'(k));
         if (k == 3) chk("R11 tx_full at depth", int'(tx_full), 1);
      end
      for (int k = 0; k < 5; k++) m_out[k] = 8'h30 + 8'(k);
      frame(5);
      for (int k = 0; k < 4; k++)
         chk("R11 tx order", int'(m_in[k]), 8'h50 + k);
      chk("R11 extra write ignored", int'(m_in[4]), int'(ENDV));
      for (int k = 0; k < 4; k++) begin
         rx_pop(v, av);
         chk("R11 rx order", int'(v), 8'h30 + k);
      end
      @(negedge clk); rx_ovf_clr = 1'b1;
      @(negedge clk); rx_ovf_clr = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule